// File: doc/BRIEF.md
# Up-down PWM timebase with shadowed compares

This block generates center-aligned pulse-width modulation. A counter climbs from zero to a programmed period, turns around, descends back to zero and repeats. Two compare channels watch the count. A match on the way up drives the channel output low, and a match on the way down drives it high. The result is a pulse centred on the count-zero point, and its width grows with the compare value.

Software writes compare values into shadow registers, and each write is first saturated to a programmed ceiling. The active compare registers take the shadow contents only when the count is zero, so a new duty cycle always starts on a period boundary. A compare value of zero holds a channel low. A value at or above the period holds it high.

A pulse at count zero lets a second instance follow as a slave. A slave with phase loading enabled reloads its count from a phase value when its sync input arrives. A slave with phase loading disabled ignores the sync input.

Top module: `pwm_ud_timebase`

## Requirements
- R1: While the period is nonzero and no phase load happens, each clock moves `count_o` by exactly one, up or down.
- R2: `dir_up_o` is 1 when the step that produced the current count was upward and 0 when it was downward. When the count equals the period, the next step goes down. When the count is zero, the next step goes up.
- R3: A period of zero holds `count_o` at 0, with `dir_up_o` at 1.
- R4: When the count equals the active compare value and that value is strictly between 0 and the period: if `dir_up_o` is 1, the channel output is 0 one clock later; if `dir_up_o` is 0, the channel output is 1 one clock later. In every other cycle the output keeps its level, except as R6 forces it.
- R5: A write pulse stores min(value, `cmp_max_i`) in the channel's shadow register. The active compare register copies the shadow register in a cycle where the count is zero. A write in that same cycle lands only in the shadow register and waits for the next zero.
- R6: An active compare value of 0 drives the output to 0 one clock later. Otherwise, an active compare value at or above the period drives the output to 1 one clock later.
- R7: `sync_o` is 1 exactly while `count_o` is 0.
- R8: If `sync_i` and `phase_en_i` are both 1 at a clock edge, the count becomes `phase_i` and `dir_up_o` becomes 1. If `phase_en_i` is 0, `sync_i` has no effect.
- R9: After reset, and for two clocks after `rst_n` rises, the count is 0, `dir_up_o` is 1, both outputs are 0 and both compare registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| period_i | input | 16 | Turnaround count |
| cmp_max_i | input | 16 | Saturation ceiling for compare writes |
| cmp_a_i | input | 16 | Compare value for channel A |
| wr_a_i | input | 1 | Write pulse for the channel A shadow register |
| cmp_b_i | input | 16 | Compare value for channel B |
| wr_b_i | input | 1 | Write pulse for the channel B shadow register |
| phase_en_i | input | 1 | Enables phase reload on sync |
| phase_i | input | 16 | Count loaded on sync |
| sync_i | input | 1 | Sync input from a master |
| sync_o | output | 1 | High at count zero |
| out_a_o | output | 1 | Channel A output |
| out_b_o | output | 1 | Channel B output |
| count_o | output | 16 | Current count |
| dir_up_o | output | 1 | Direction of the last step |

## Verification
A compare write can arrive in the same cycle that the count sits at zero and the active register reloads. The bench provokes this by waiting for `count_o` to read zero and then pulsing the write. The bench's model expects the old shadow contents to become active and the new value to wait a full period. A sync with phase loading can also coincide with a turnaround or a zero reload. The randomized stretch produces these coincidences, and the model judges them on every clock by comparing the count, the direction, the sync output and both channel outputs.

// File: rtl/pwm_ud_pkg.sv
package pwm_ud_pkg;
  localparam logic DIR_UP   = 1'b1;
  localparam logic DIR_DOWN = 1'b0;
  localparam int   NUM_CH   = 2;
endpackage

// File: rtl/pwm_ud_rst_sync.sv
module pwm_ud_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_sync_n = ff2_q;
endmodule

// File: rtl/pwm_ud_counter.sv
module pwm_ud_counter
  import pwm_ud_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] phase_i,
  input  logic         phase_en_i,
  input  logic         sync_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d;
  logic         load_phase, step_up;

  // next-state
  always_comb begin
    load_phase = sync_i & phase_en_i;
    step_up    = (cnt_q == '0) | (dir_q & (cnt_q < period_i));
    if (load_phase) begin
      cnt_d = phase_i;
      dir_d = DIR_UP;
    end else if (period_i == '0) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (step_up) begin
      cnt_d = cnt_q + ONE;
      dir_d = DIR_UP;
    end else begin
      cnt_d = cnt_q - ONE;
      dir_d = DIR_DOWN;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;
  assign zero_o = (cnt_q == '0);

  // R1: single-step movement
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_phase) && $past(period_i) != '0) |->
      (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));

  // R2: turnaround at the period
  a_r2_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_phase) && $past(period_i) != '0 && $past(cnt_q) == $past(period_i))
      |-> (dir_q == DIR_DOWN));

  // R3: zero period holds the count
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_phase) && $past(period_i) == '0) |-> (cnt_q == '0));

  // R8: phase reload on sync
  a_r8_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_phase) |-> (cnt_q == $past(phase_i) && dir_q == DIR_UP));
endmodule

// File: rtl/pwm_ud_channel.sv
module pwm_ud_channel
  import pwm_ud_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         dir_i,
  input  logic         zero_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] max_i,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  output logic         out_o
);
  logic [W-1:0] shadow_q, shadow_d, active_q, active_d;
  logic         out_q, out_d;
  logic         shadow_en, active_en, hit;

  // next-state
  always_comb begin
    shadow_en = wr_i;
    active_en = zero_i;
    shadow_d  = (val_i > max_i) ? max_i : val_i;
    active_d  = shadow_q;
    hit       = (cnt_i == active_q);
    if (active_q == '0)             out_d = 1'b0;
    else if (active_q >= period_i)  out_d = 1'b1;
    else if (hit)                   out_d = (dir_i == DIR_DOWN);
    else                            out_d = out_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      out_q    <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (active_en) active_q <= active_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  // R5: reload only at zero, from the old shadow contents
  a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_i) |-> (active_q == $past(shadow_q)));
  a_r5_hold_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(zero_i) |-> $stable(active_q));

  // R6: zero compare forces low
  a_r6_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active_q) == '0) |-> !out_o);

  // R4: up-count match clears
  a_r4_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_i) == $past(active_q) && $past(dir_i) == DIR_UP &&
     $past(active_q) != '0 && $past(active_q) < $past(period_i)) |-> !out_o);
endmodule

// File: rtl/pwm_ud_timebase.sv
module pwm_ud_timebase
  import pwm_ud_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] cmp_max_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic         wr_a_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic         wr_b_i,
  input  logic         phase_en_i,
  input  logic [W-1:0] phase_i,
  input  logic         sync_i,
  output logic         sync_o,
  output logic         out_a_o,
  output logic         out_b_o,
  output logic [W-1:0] count_o,
  output logic         dir_up_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         rst_sync_n;
  logic [W-1:0] cnt;
  logic         dir, zero;
  logic [W-1:0] ch_val [NUM_CH];
  logic         ch_wr  [NUM_CH];
  logic         ch_out [NUM_CH];

  assign ch_val[0] = cmp_a_i;
  assign ch_val[1] = cmp_b_i;
  assign ch_wr[0]  = wr_a_i;
  assign ch_wr[1]  = wr_b_i;

  pwm_ud_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_ud_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .period_i   (period_i),
    .phase_i    (phase_i),
    .phase_en_i (phase_en_i),
    .sync_i     (sync_i),
    .cnt_o      (cnt),
    .dir_o      (dir),
    .zero_o     (zero)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_ud_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cnt_i    (cnt),
      .dir_i    (dir),
      .zero_i   (zero),
      .period_i (period_i),
      .max_i    (cmp_max_i),
      .wr_i     (ch_wr[g]),
      .val_i    (ch_val[g]),
      .out_o    (ch_out[g])
    );
  end

  assign sync_o   = zero;
  assign out_a_o  = ch_out[0];
  assign out_b_o  = ch_out[1];
  assign count_o  = cnt;
  assign dir_up_o = dir;

  // R7: the cycle after a sync pulse the count has left zero upward
  a_r7_sync_then_one: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(sync_o) && !$past(sync_i && phase_en_i) && $past(period_i) != '0)
      |-> (count_o == ONE));
endmodule

// File: tb/pwm_ud_timebase_bench.sv
module pwm_ud_timebase_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] period_i, cmp_max_i, cmp_a_i, cmp_b_i, phase_i;
  logic        wr_a_i, wr_b_i, phase_en_i, sync_i;
  logic        sync_o, out_a_o, out_b_o, dir_up_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_ud_timebase u_pwm_ud_timebase (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .cmp_max_i(cmp_max_i),
    .cmp_a_i(cmp_a_i), .wr_a_i(wr_a_i), .cmp_b_i(cmp_b_i), .wr_b_i(wr_b_i),
    .phase_en_i(phase_en_i), .phase_i(phase_i), .sync_i(sync_i),
    .sync_o(sync_o), .out_a_o(out_a_o), .out_b_o(out_b_o),
    .count_o(count_o), .dir_up_o(dir_up_o)
  );

  // reference model state
  int m_cnt, m_dir, m_rs1, m_rs2;
  int m_sh[2], m_act[2], m_out[2];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int sat(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_cnt = 0; m_dir = 1;
      for (int i = 0; i < 2; i++) begin m_sh[i] = 0; m_act[i] = 0; m_out[i] = 0; end
    end else begin
      if (m_rs2 == 0) begin
        m_rs2 = m_rs1;
        m_rs1 = 1;
      end else begin
        int per, nval[2], nwr[2];
        per = int'(period_i);
        nval[0] = int'(cmp_a_i); nval[1] = int'(cmp_b_i);
        nwr[0]  = int'(wr_a_i);  nwr[1]  = int'(wr_b_i);
        for (int i = 0; i < 2; i++) begin
          if (m_act[i] == 0) m_out[i] = 0;
          else if (m_act[i] >= per) m_out[i] = 1;
          else if (m_cnt == m_act[i]) m_out[i] = (m_dir == 1) ? 0 : 1;
          if (m_cnt == 0) m_act[i] = m_sh[i];
          if (nwr[i] != 0) m_sh[i] = sat(nval[i], int'(cmp_max_i));
        end
        if (sync_i && phase_en_i) begin m_cnt = int'(phase_i); m_dir = 1; end
        else if (per == 0) begin m_cnt = 0; m_dir = 1; end
        else if (m_cnt == 0 || (m_dir == 1 && m_cnt < per)) begin m_cnt++; m_dir = 1; end
        else begin m_cnt--; m_dir = 0; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(count_o) == m_cnt, "R1 R3 R8 count", int'(count_o), m_cnt);
      check(int'(dir_up_o) == m_dir, "R2 dir", int'(dir_up_o), m_dir);
      check(int'(sync_o) == (m_cnt == 0 ? 1 : 0), "R7 sync", int'(sync_o), (m_cnt == 0 ? 1 : 0));
      check(int'(out_a_o) == m_out[0], "R4 R5 R6 out_a", int'(out_a_o), m_out[0]);
      check(int'(out_b_o) == m_out[1], "R4 R5 R6 out_b", int'(out_b_o), m_out[1]);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_LIMIT);
      finish_run();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ch(int ch, int v);
    @(negedge clk);
    if (ch == 0) begin cmp_a_i = 16'(v); wr_a_i = 1'b1; end
    else begin cmp_b_i = 16'(v); wr_b_i = 1'b1; end
    @(negedge clk);
    wr_a_i = 1'b0; wr_b_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; period_i = '0; cmp_max_i = 16'hFFFF; cmp_a_i = '0; cmp_b_i = '0;
    phase_i = '0; wr_a_i = 0; wr_b_i = 0; phase_en_i = 0; sync_i = 0;
    idle(3);
    rst_n = 1'b1;
    // R9: state held through the synchronized release
    @(negedge clk);
    check(count_o == 0, "R9 reset count", int'(count_o), 0);
    check(dir_up_o == 1'b1, "R9 reset dir", int'(dir_up_o), 1);
    check(out_a_o == 1'b0 && out_b_o == 1'b0, "R9 reset outputs", int'({out_a_o, out_b_o}), 0);
    idle(3);

    // main function
    period_i = 16'd20;
    write_ch(0, 5);
    write_ch(1, 15);
    idle(100);

    // collision: write while the count sits at zero (R5)
    while (count_o != 0) @(negedge clk);
    cmp_a_i = 16'd12; wr_a_i = 1'b1;
    @(negedge clk);
    wr_a_i = 1'b0;
    idle(90);

    // forced levels (R6)
    write_ch(0, 0);
    write_ch(1, 25);
    idle(60);
    check(out_a_o == 1'b0, "R6 zero compare low", int'(out_a_o), 0);
    check(out_b_o == 1'b1, "R6 compare above period high", int'(out_b_o), 1);

    // saturation (R5)
    cmp_max_i = 16'd8;
    write_ch(0, 30);
    idle(60);
    while (!(count_o == 16'd4 && dir_up_o == 1'b0)) @(negedge clk);
    @(negedge clk);
    check(out_a_o == 1'b1, "R5 saturated compare", int'(out_a_o), 1);
    cmp_max_i = 16'hFFFF;

    // zero period (R3)
    period_i = 16'd0;
    idle(20);
    check(count_o == 0, "R3 zero period holds", int'(count_o), 0);

    // phase reload on sync (R8)
    period_i = 16'd30;
    idle(10);
    sync_i = 1'b1; phase_en_i = 1'b1; phase_i = 16'd7;
    @(negedge clk);
    sync_i = 1'b0;
    check(count_o == 16'd7, "R8 phase load count", int'(count_o), 7);
    check(dir_up_o == 1'b1, "R8 phase load dir", int'(dir_up_o), 1);
    idle(5);
    phase_en_i = 1'b0; sync_i = 1'b1; phase_i = 16'd2;
    @(negedge clk);
    sync_i = 1'b0;
    check(count_o == 16'd13, "R8 sync ignored", int'(count_o), 13);
    phase_en_i = 1'b1; sync_i = 1'b1; phase_i = 16'd40;
    @(negedge clk);
    sync_i = 1'b0;
    idle(50);

    // randomized stretch
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(63) == 0) period_i = 16'($urandom_range(31));
      if ($urandom_range(63) == 0) cmp_max_i = 16'($urandom_range(40));
      wr_a_i = ($urandom_range(7) == 0);
      wr_b_i = ($urandom_range(7) == 0);
      cmp_a_i = 16'($urandom_range(40));
      cmp_b_i = 16'($urandom_range(40));
      sync_i = ($urandom_range(15) == 0);
      phase_en_i = 1'($urandom_range(1));
      phase_i = 16'($urandom_range(40));
      @(negedge clk);
    end
    wr_a_i = 0; wr_b_i = 0; sync_i = 0;
    idle(5);
    finish_run();
  end
endmodule